// File: doc/BRIEF.md
# PCI clock stop sequencer

This block decides, cycle by cycle, which outputs of a clock generator may pass their clock. It drives one gate enable for each of seven stoppable PCI clock outputs and three outputs in the free-running PCI domain, and it drives a two-bit state code for a differential SRC pair. The clock waveforms are produced elsewhere. Each gated clock is formed outside the block as the source clock ANDed with its gate, and the SRC driver reads the state code.

A stop can be requested in two ways: the active-low stop pin, or a software run bit written 0. The request is synchronized into the PCI clock domain on rising edges. The PCI gates then close on a falling edge, so every pulse already started is completed. Only after the PCI gates are closed does the request reach the SRC domain, where the pair stops on an SRC rising edge. It is then either held driven (true high, complement low) or tri-stated, as a drive-mode bit selects. On release the PCI gates reopen on a falling edge and the SRC pair resumes on a rising edge, so no shortened pulse appears on any output.

Top module: `pci_stop_seq`

## Requirements
- R1: While reset is asserted, every PCI gate and free-domain gate is 0 and the SRC state code is 2'b01 (held driven).
- R2: The stop request is active when `stop_n` is 0 or `sw_run` is 0. It is sampled on rising edges of `clk_pci`, and the outputs stop only while at least one of the two sources is active.
- R3: During a stop request every `pci_gate` bit is 0. A free-domain output whose `free_stoppable` bit is 1 gets a gate of 0. A free-domain output whose `free_stoppable` bit is 0 keeps following its enable bit.
- R4: An output whose enable bit (`pci_en` or `free_en`) is 0 has a gate of 0. With no stop request, each gate equals its enable bit.
- R5: Gates change only on falling edges of `clk_pci`, and the SRC state code changes only on rising edges of `clk_src`, so no gated clock pulse is truncated.
- R6: The SRC pair leaves running (code 2'b00) for a stopped code only when all stoppable PCI gates are already 0. The stopped code is 2'b01 (true high, complement low) when `src_tri` is 0 and 2'b10 (tri-stated) when `src_tri` is 1. Code 2'b11 never appears.
- R7: With `src_free` = 1 and `src_en` = 1, the SRC code stays 2'b00 regardless of the stop request.
- R8: With `src_en` = 0, the SRC code is 2'b10 (tri-stated) regardless of the stop request or the drive mode.
- R9: After the request is released, the PCI gates return to their enable bits and the SRC code returns to 2'b00, each within ten `clk_pci` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci | input | 1 | Free-running PCI reference clock |
| clk_src | input | 1 | SRC pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Active-low stop pin, asynchronous |
| sw_run | input | 1 | Software run bit; 0 requests a stop |
| pci_en | input | N_PCI | Enable for each stoppable PCI output |
| free_en | input | N_FREE | Enable for each free-domain output |
| free_stoppable | input | N_FREE | 1 makes that free-domain output obey stops |
| src_en | input | 1 | SRC pair enable; 0 tri-states the pair |
| src_free | input | 1 | 1 keeps SRC running through stops |
| src_tri | input | 1 | 1 tri-states the pair when stopped |
| pci_gate | output | N_PCI | Gate for each stoppable PCI output |
| free_gate | output | N_FREE | Gate for each free-domain output |
| src_state | output | 2 | 00 running, 01 held driven, 10 tri-stated |

## Verification
The hardest case to reach from the ports is the moment when the SRC pair leaves running, because it happens in a different clock domain some cycles after the PCI gates close. The bench uses two clocks whose edges never line up. It sweeps every combination of free-domain stop mask, request source, SRC free-running bit and SRC drive mode. A monitor checks each SRC change against the PCI gates at the instant it happens and checks the phase of each clock whenever a gate moves. Further directed steps overlap the pin and software requests, change enables while stopped, and disable the SRC pair during a stop.

// File: rtl/pci_stop_seq.sv
module pci_stop_seq #(
  parameter int N_PCI  = 7,
  parameter int N_FREE = 3
) (
  input  logic              clk_pci,
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              stop_n,
  input  logic              sw_run,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_FREE-1:0] free_en,
  input  logic [N_FREE-1:0] free_stoppable,
  input  logic              src_en,
  input  logic              src_free,
  input  logic              src_tri,
  output logic [N_PCI-1:0]  pci_gate,
  output logic [N_FREE-1:0] free_gate,
  output logic [1:0]        src_state
);
  localparam logic [1:0] SRC_RUN  = 2'b00;
  localparam logic [1:0] SRC_HELD = 2'b01;
  localparam logic [1:0] SRC_OFF  = 2'b10;

  logic [1:0] req_sync;
  logic [1:0] halt_sync;
  logic       pci_halt;
  logic [1:0] src_next;

  wire stop_req = ~stop_n | ~sw_run;
  wire req_q    = req_sync[1];

  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) req_sync <= 2'b11;
    else        req_sync <= {req_sync[0], stop_req};

  always_ff @(negedge clk_pci or negedge rst_n)
    if (!rst_n) begin
      pci_halt  <= 1'b1;
      pci_gate  <= '0;
      free_gate <= '0;
    end else begin
      pci_halt  <= req_q;
      pci_gate  <= pci_en & ~{N_PCI{req_q}};
      free_gate <= free_en & ~(free_stoppable & {N_FREE{req_q}});
    end

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) halt_sync <= 2'b11;
    else        halt_sync <= {halt_sync[0], pci_halt};

  always_comb begin
    if (!src_en)                      src_next = SRC_OFF;
    else if (src_free || !halt_sync[1]) src_next = SRC_RUN;
    else if (src_tri)                 src_next = SRC_OFF;
    else                              src_next = SRC_HELD;
  end

  always_ff @(posedge clk_src or negedge rst_n)
    if (!rst_n) src_state <= SRC_HELD;
    else        src_state <= src_next;
endmodule

module pci_stop_seq_chk #(
  parameter int N_PCI  = 7,
  parameter int N_FREE = 3
) (
  input logic              clk_pci,
  input logic              clk_src,
  input logic              rst_n,
  input logic [N_PCI-1:0]  pci_en,
  input logic [N_FREE-1:0] free_en,
  input logic [N_FREE-1:0] free_stoppable,
  input logic              src_en,
  input logic              src_free,
  input logic              src_tri,
  input logic [N_PCI-1:0]  pci_gate,
  input logic [N_FREE-1:0] free_gate,
  input logic [1:0]        src_state,
  input logic              pci_halt
);
  // R4
  pci_enable_chk: assert property (@(negedge clk_pci) disable iff (!rst_n)
    $past(rst_n) |-> ((pci_gate & ~$past(pci_en)) == '0));

  // R4
  free_enable_chk: assert property (@(negedge clk_pci) disable iff (!rst_n)
    $past(rst_n) |-> ((free_gate & ~$past(free_en)) == '0));

  // R3
  free_running_chk: assert property (@(negedge clk_pci) disable iff (!rst_n)
    $past(rst_n) |-> (($past(free_en & ~free_stoppable) & ~free_gate) == '0));

  // R6
  src_order_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($past(rst_n) && src_en && $past(src_en) && $past(src_state) == 2'b00 && src_state != 2'b00)
      |-> pci_halt);

  // R6
  src_code_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    src_state != 2'b11);

  // R6
  src_tri_mode_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($past(rst_n) && $past(src_en && !src_free && src_tri)) |-> src_state != 2'b01);

  // R7
  src_free_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($past(rst_n) && $past(src_en && src_free)) |-> src_state == 2'b00);

  // R8
  src_disable_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($past(rst_n) && $past(!src_en)) |-> src_state == 2'b10);
endmodule

bind pci_stop_seq pci_stop_seq_chk #(.N_PCI(N_PCI), .N_FREE(N_FREE)) u_chk (
  .clk_pci(clk_pci), .clk_src(clk_src), .rst_n(rst_n),
  .pci_en(pci_en), .free_en(free_en), .free_stoppable(free_stoppable),
  .src_en(src_en), .src_free(src_free), .src_tri(src_tri),
  .pci_gate(pci_gate), .free_gate(free_gate), .src_state(src_state),
  .pci_halt(pci_halt)
);

// File: tb/sim_pci_stop_seq.sv
`timescale 1ns/100ps
module sim_pci_stop_seq;
  logic       clk_pci = 1'b0;
  logic       clk_src = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_n = 1'b1;
  logic       sw_run = 1'b1;
  logic [6:0] pci_en = '1;
  logic [2:0] free_en = '1;
  logic [2:0] free_stoppable = '0;
  logic       src_en = 1'b1;
  logic       src_free = 1'b0;
  logic       src_tri = 1'b0;
  logic [6:0] pci_gate;
  logic [2:0] free_gate;
  logic [1:0] src_state;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  pci_stop_seq u0 (
    .clk_pci(clk_pci), .clk_src(clk_src), .rst_n(rst_n),
    .stop_n(stop_n), .sw_run(sw_run),
    .pci_en(pci_en), .free_en(free_en), .free_stoppable(free_stoppable),
    .src_en(src_en), .src_free(src_free), .src_tri(src_tri),
    .pci_gate(pci_gate), .free_gate(free_gate), .src_state(src_state)
  );

  always #4 clk_pci = ~clk_pci;
  initial begin
    #1.5;
    forever #3 clk_src = ~clk_src;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_pci(input int n);
    repeat (n) @(posedge clk_pci);
    #1;
  endtask

  function automatic logic [1:0] stop_code();
    if (!src_en) return 2'b10;
    if (src_free) return 2'b00;
    return src_tri ? 2'b10 : 2'b01;
  endfunction

  task automatic check_run(input string tag);
    chk({tag, " pci gates"}, 16'(pci_gate), 16'(pci_en));
    chk({tag, " free gates"}, 16'(free_gate), 16'(free_en));
    chk({tag, " src code"}, 16'(src_state), src_en ? 16'h0 : 16'h2);
  endtask

  task automatic check_stop(input string tag);
    chk({tag, " pci gates"}, 16'(pci_gate), 16'h0);
    chk({tag, " free gates"}, 16'(free_gate), 16'(free_en & ~free_stoppable));
    chk({tag, " src code"}, 16'(src_state), 16'(stop_code()));
  endtask

  // R5: gates move only while clk_pci is low
  always @(pci_gate or free_gate)
    if (rst_n && !done) begin
      checks++;
      if (clk_pci !== 1'b0) begin
        fails++;
        $display("FAIL R5 gate moved with clk_pci=%b expected 0 at %0t", clk_pci, $time);
      end
    end

  // R5 and R6: SRC code moves only while clk_src is high, and stops only after PCI is low
  logic [1:0] prev_src = 2'b01;
  always @(src_state) begin
    if (rst_n && !done) begin
      checks++;
      if (clk_src !== 1'b1) begin
        fails++;
        $display("FAIL R5 src code moved with clk_src=%b expected 1 at %0t", clk_src, $time);
      end
      if (src_en && prev_src == 2'b00 && src_state != 2'b00) begin
        checks++;
        if (pci_gate != 0 || (free_gate & free_stoppable) != 0) begin
          fails++;
          $display("FAIL R6 src stopped with pci_gate=%h free=%h expected 0 at %0t",
                   pci_gate, free_gate & free_stoppable, $time);
        end
      end
    end
    prev_src = src_state;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #21;
    chk("R1 reset pci gates", 16'(pci_gate), 16'h0);
    chk("R1 reset free gates", 16'(free_gate), 16'h0);
    chk("R1 reset src code", 16'(src_state), 16'h1);
    #9 rst_n = 1'b1;
    wait_pci(8);
    check_run("R4 after reset");

    for (int c = 0; c < 64; c++) begin
      free_stoppable = 3'(c);
      src_free = c[4];
      src_tri = c[5];
      pci_en = (c % 4 == 0) ? 7'h7f : 7'(c * 37 + 11);
      free_en = (c % 3 == 0) ? 3'h7 : 3'(c * 5 + 1);
      wait_pci(6);
      check_run("R4 sweep run");
      if (c[3]) sw_run = 1'b0;
      else stop_n = 1'b0;
      wait_pci(10);
      check_stop(c[3] ? "R2 R3 R6 R7 sweep sw stop" : "R2 R3 R6 R7 sweep pin stop");
      stop_n = 1'b1;
      sw_run = 1'b1;
      wait_pci(10);
      check_run("R9 sweep resume");
    end

    // R2: overlapping sources, one released
    free_stoppable = 3'b101; src_free = 0; src_tri = 0;
    pci_en = 7'h55; free_en = 3'h7;
    stop_n = 0; sw_run = 0;
    wait_pci(10);
    check_stop("R2 both sources");
    stop_n = 1;
    wait_pci(10);
    check_stop("R2 software still low");
    // R4: enables changed while stopped
    pci_en = 7'h2a; free_en = 3'b011;
    wait_pci(4);
    check_stop("R4 enables during stop");
    sw_run = 1;
    wait_pci(10);
    check_run("R9 resume after overlap");

    // R8: disabled SRC pair
    src_en = 0;
    wait_pci(4);
    chk("R8 disabled running", 16'(src_state), 16'h2);
    stop_n = 0;
    wait_pci(10);
    check_stop("R8 disabled stopped");
    src_en = 1;
    wait_pci(4);
    chk("R6 held after enable", 16'(src_state), 16'h1);
    stop_n = 1;
    wait_pci(10);
    check_run("R9 final resume");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule